// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block is a synchronous controller that updates one of up to four parallel-input DACs. Each DAC's data register is a level-sensitive latch behind an active-low enable. A host hands over a request that carries a 2-bit channel number and a 12-bit straight-binary code. Code 0x000 means zero scale and 0xFFF means full scale. The host may instead raise a clear flag with the request. The controller passes the 12-bit code over an 8-bit shared bus in two byte transfers. An external pair of byte-steering latches, driven by a high/low select line, assembles the two bytes. The controller then pulses the enable of the addressed DAC only, holds the bus for a hold window, and reports completion with a one-cycle done strobe.

The timing minimums for byte capture, data setup, enable width, data hold and clear width are parameters counted in clock cycles. Every output is registered. The channel decoder only acts on an address that was registered before the decoder is enabled. This keeps the enables free of glitches. A clear request drives the shared active-low clear line for a fixed number of cycles and never overlaps an enable pulse.

Top module: `dac_wr_seq`

## Requirements
- R1: While reset is asserted, and after it, until a request is accepted: all enables are high, clear is high, select is low, and busy, done and ack are low. Asserting reset during a sequence returns the outputs to this state at once.
- R2: A write first drives select high for T_BYTE cycles. During that time the bus carries code bits 11..8 in bus bits 3..0, with bus bits 7..4 at zero. Select then goes low and the bus carries code bits 7..0.
- R3: Only enable bit `req_chan` (bit i serves channel i) goes low during a write. All other enables stay high.
- R4: The low byte is on the bus with select low for exactly T_DS cycles before the enable falls. The enable stays low for exactly T_CEW cycles.
- R5: After the enable rises, the bus and select stay unchanged for T_DH cycles while busy stays high.
- R6: A request is accepted only when the block is idle. Ack is high for one cycle, in the cycle after the accepting edge, and busy is high in that same cycle. Done is high for one cycle, in the first cycle in which busy is low again.
- R7: A request raised while busy is ignored. No second sequence starts, and no DAC register changes.
- R8: A request with the clear flag set drives clear low for exactly T_CLRW cycles, with all enables high. The code and channel of that request are ignored, and every DAC register reads zero afterwards.
- R9: After a write, the addressed DAC register (assembled as high nibble and low byte) holds the requested code. The other channels keep their values.
- R10: A write keeps busy high for exactly T_BYTE+T_DS+T_CEW+T_DH cycles. A clear keeps busy high for exactly T_CLRW cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe from host |
| req_clear | input | 1 | Request is a clear, not a write |
| req_chan | input | 2 | Target DAC channel |
| req_code | input | 12 | Straight-binary code to load |
| req_ack | output | 1 | One-cycle accept acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| bus_data | output | 8 | Shared byte bus to the steering latches |
| byte_hi | output | 1 | High/low byte select (high = upper byte) |
| ce_n | output | 4 | Per-channel active-low enables |
| clr_n | output | 1 | Shared active-low clear |

## Verification
The bench models the external byte latch and the four DAC latches, so a wrong byte order or a nonzero upper nibble shows up as a wrong code in the model. An off-by-one phase counter changes the measured setup, enable, hold or busy counts. A decoder that fires the wrong lane, or more than one lane, corrupts the register of another channel. The bench also fires a second request while a write is running, where a design that fails to block it would start a second write to another channel. It issues a clear between writes, where an overlap with an enable or a leaked code would show. Finally, it asserts reset in the middle of a write, where any output left active would be seen.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HI   = 3'd1,
    ST_LO   = 3'd2,
    ST_CE   = 3'd3,
    ST_HOLD = 3'd4,
    ST_CLR  = 3'd5
  } seq_state_t;

  function automatic int max5(input int a, input int b, input int c,
                              input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (!expired) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ch_decode.sv
module ch_decode #(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CH-1:0] ce_n
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
    logic lane_d;
    assign lane_d = !(en && (sel == SEL_W'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ce_n[i] <= 1'b1;
      end else begin
        ce_n[i] <= lane_d;
      end
    end
  end

endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8,
  parameter int T_BYTE = 2,
  parameter int T_DS   = 8,
  parameter int T_CEW  = 8,
  parameter int T_DH   = 3,
  parameter int T_CLRW = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_clear,
  input  logic [$clog2(NUM_CH)-1:0] req_chan,
  input  logic [CODE_W-1:0]         req_code,
  output logic                      req_ack,
  output logic                      busy,
  output logic                      done,
  output logic [BUS_W-1:0]          bus_data,
  output logic                      byte_hi,
  output logic [NUM_CH-1:0]         ce_n,
  output logic                      clr_n
);

  localparam int SEL_W = $clog2(NUM_CH);
  localparam int HI_W  = CODE_W - BUS_W;
  localparam int T_MAX = max5(T_BYTE, T_DS, T_CEW, T_DH, T_CLRW);
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic              rst_n_i;
  seq_state_t        state_q, state_d;
  logic [SEL_W-1:0]  chan_q, chan_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              accept;
  logic              t_load, t_exp;
  logic [CNT_W-1:0]  t_val;
  logic [BUS_W-1:0]  bus_d;
  logic              bus_en;

  rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign accept = (state_q == ST_IDLE) && req_valid;
  assign chan_d = accept ? req_chan : chan_q;
  assign code_d = accept ? req_code : code_q;

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = req_clear ? ST_CLR : ST_HI;
      ST_HI:   if (t_exp) state_d = ST_LO;
      ST_LO:   if (t_exp) state_d = ST_CE;
      ST_CE:   if (t_exp) state_d = ST_HOLD;
      ST_HOLD: if (t_exp) state_d = ST_IDLE;
      ST_CLR:  if (t_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // phase length on entry
  always_comb begin
    t_load = (state_d != state_q) && (state_d != ST_IDLE);
    unique case (state_d)
      ST_HI:   t_val = CNT_W'(T_BYTE - 1);
      ST_LO:   t_val = CNT_W'(T_DS - 1);
      ST_CE:   t_val = CNT_W'(T_CEW - 1);
      ST_HOLD: t_val = CNT_W'(T_DH - 1);
      ST_CLR:  t_val = CNT_W'(T_CLRW - 1);
      default: t_val = '0;
    endcase
  end

  phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  // bus contents for the coming phase
  always_comb begin
    bus_en = 1'b0;
    bus_d  = bus_data;
    unique case (state_d)
      ST_HI: begin
        bus_en = 1'b1;
        bus_d  = {{(BUS_W-HI_W){1'b0}}, code_d[CODE_W-1:BUS_W]};
      end
      ST_LO, ST_CE, ST_HOLD: begin
        bus_en = 1'b1;
        bus_d  = code_d[BUS_W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q  <= ST_IDLE;
      chan_q   <= '0;
      code_q   <= '0;
      bus_data <= '0;
      byte_hi  <= 1'b0;
      clr_n    <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      req_ack  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        chan_q <= chan_d;
        code_q <= code_d;
      end
      if (bus_en) bus_data <= bus_d;
      byte_hi <= (state_d == ST_HI);
      clr_n   <= (state_d != ST_CLR);
      busy    <= (state_d != ST_IDLE);
      done    <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
      req_ack <= accept;
    end
  end

  ch_decode #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n_i),
    .en    (state_d == ST_CE),
    .sel   (chan_d),
    .ce_n  (ce_n)
  );

  // ---------------- assertions ----------------
  logic             ce_all_hi;
  logic [CNT_W:0]   ce_run, clr_run;
  logic [CNT_W-1:0] hold_left;
  logic             ce_all_hi_q;
  logic             ce_rise;

  assign ce_all_hi = &ce_n;
  assign ce_rise   = ce_all_hi && !ce_all_hi_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ce_run      <= '0;
      clr_run     <= '0;
      hold_left   <= '0;
      ce_all_hi_q <= 1'b1;
    end else begin
      ce_all_hi_q <= ce_all_hi;
      ce_run      <= ce_all_hi ? '0 : ce_run + 1'b1;
      clr_run     <= clr_n ? '0 : clr_run + 1'b1;
      if (ce_rise) hold_left <= CNT_W'(T_DH - 1);
      else if (hold_left != '0) hold_left <= hold_left - 1'b1;
    end
  end

  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(~ce_n));
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n_i)
    !clr_n |-> ce_all_hi);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    byte_hi |-> ((bus_data >> HI_W) == '0));
  a_r4_ce_width: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(ce_all_hi) |-> (ce_run == (CNT_W+1)'(T_CEW)));
  a_r8_clr_width: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(clr_n) |-> (clr_run == (CNT_W+1)'(T_CLRW)));
  a_r5_bus_held: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!ce_all_hi || ce_rise || hold_left != '0) |-> ($stable(bus_data) && !byte_hi && busy));
  a_r6_done_once: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> !done);
  a_r6_ack_busy: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_ack |-> busy);

endmodule

// File: tb/tb_dac_wr_seq.sv
`timescale 1ns/1ps
module tb_dac_wr_seq;

  localparam int T_BYTE = 2, T_DS = 8, T_CEW = 8, T_DH = 3, T_CLRW = 5;
  localparam int WR_LEN = T_BYTE + T_DS + T_CEW + T_DH;

  // {clear, chan[1:0], code[11:0]}
  localparam logic [14:0] VEC [0:7] = '{
    {1'b0, 2'd0, 12'hABC}, {1'b0, 2'd1, 12'hFFF}, {1'b0, 2'd2, 12'h000},
    {1'b0, 2'd3, 12'h5A5}, {1'b0, 2'd0, 12'h800}, {1'b1, 2'd2, 12'h777},
    {1'b0, 2'd2, 12'h123}, {1'b0, 2'd1, 12'h0F0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_clear;
  logic [1:0]  req_chan;
  logic [11:0] req_code;
  logic        req_ack, busy, done, byte_hi, clr_n;
  logic [7:0]  bus_data;
  logic [3:0]  ce_n;

  always #2 clk = ~clk;

  dac_wr_seq #(.T_BYTE(T_BYTE), .T_DS(T_DS), .T_CEW(T_CEW), .T_DH(T_DH),
               .T_CLRW(T_CLRW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_clear(req_clear),
    .req_chan(req_chan), .req_code(req_code), .req_ack(req_ack), .busy(busy),
    .done(done), .bus_data(bus_data), .byte_hi(byte_hi), .ce_n(ce_n),
    .clr_n(clr_n));

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // external latch + DAC models and monitor
  logic [7:0]  hi_lat;
  logic [11:0] dac [4];
  logic [11:0] exp_dac [4];
  logic [7:0]  lo_exp;
  int busy_cyc, done_cyc, ack_cyc, ce_cyc, pre_cyc, last_pre, post_cyc, clr_cyc;
  logic [3:0] lanes;
  logic hold_bad, overlap, ce_prev_hi;

  task automatic clear_mon();
    busy_cyc = 0; done_cyc = 0; ack_cyc = 0; ce_cyc = 0; pre_cyc = 0;
    last_pre = -1; post_cyc = 0; clr_cyc = 0; lanes = '0;
    hold_bad = 1'b0; overlap = 1'b0;
  endtask

  initial begin
    hi_lat = '0; ce_prev_hi = 1'b1; lo_exp = '0;
    for (int i = 0; i < 4; i++) begin dac[i] = '0; exp_dac[i] = '0; end
    clear_mon();
  end

  always @(negedge clk) begin
    if (byte_hi) begin hi_lat = bus_data; pre_cyc = 0; end
    if (busy) busy_cyc++;
    if (done) done_cyc++;
    if (req_ack) ack_cyc++;
    if (!(&ce_n)) begin
      if (ce_prev_hi) last_pre = pre_cyc;
      ce_cyc++;
      lanes = lanes | ~ce_n;
    end else if (busy && !byte_hi && clr_n) begin
      if (ce_cyc == 0) pre_cyc++;
      else begin
        post_cyc++;
        if (bus_data !== lo_exp) hold_bad = 1'b1;
      end
    end
    if (!clr_n) begin
      clr_cyc++;
      if (!(&ce_n)) overlap = 1'b1;
      for (int i = 0; i < 4; i++) dac[i] = '0;
    end else begin
      for (int i = 0; i < 4; i++)
        if (!ce_n[i]) dac[i] = {hi_lat[3:0], bus_data};
    end
    ce_prev_hi = &ce_n;
  end

  task automatic run_req(input logic clr, input logic [1:0] ch, input logic [11:0] code);
    int guard;
    clear_mon();
    lo_exp = code[7:0];
    @(negedge clk); #1;
    req_valid = 1'b1; req_clear = clr; req_chan = ch; req_code = code;
    @(negedge clk); #1;
    chk("R6 ack after accept", req_ack, 1'b1);
    chk("R6 busy with ack", busy, 1'b1);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 200) begin @(negedge clk); #1; guard++; end
    chk("R6 done seen", done, 1'b1);
    chk("R6 busy low at done", busy, 1'b0);
    chk("R6 single ack", ack_cyc, 1);
    if (clr) begin
      for (int i = 0; i < 4; i++) exp_dac[i] = '0;
      chk("R8 clear width", clr_cyc, T_CLRW);
      chk("R8 no enable during clear", {overlap, lanes}, 5'd0);
      chk("R10 clear busy length", busy_cyc, T_CLRW);
    end else begin
      exp_dac[ch] = code;
      chk("R2 upper byte", hi_lat, {4'h0, code[11:8]});
      chk("R4 setup cycles", last_pre, T_DS);
      chk("R4 enable width", ce_cyc, T_CEW);
      chk("R3 enable lane", lanes, 4'b0001 << ch);
      chk("R5 hold cycles", post_cyc, T_DH);
      chk("R5 hold bus stable", hold_bad, 1'b0);
      chk("R10 write busy length", busy_cyc, WR_LEN);
      chk("R8 clear idle in write", clr_cyc, 0);
    end
    for (int i = 0; i < 4; i++) chk("R9 DAC register", dac[i], exp_dac[i]);
    @(negedge clk); #1;
    chk("R6 done one cycle", done, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_clear = 1'b0; req_chan = '0; req_code = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset enables", ce_n, 4'hF);
    chk("R1 reset clear", clr_n, 1'b1);
    chk("R1 reset flags", {busy, done, req_ack, byte_hi}, 4'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 idle after release", {busy, done, req_ack, byte_hi, clr_n, ce_n}, {4'd0, 1'b1, 4'hF});

    // table walk
    for (int v = 0; v < 8; v++)
      run_req(VEC[v][14], VEC[v][13:12], VEC[v][11:0]);

    // R7: request while busy is ignored
    clear_mon();
    lo_exp = 8'h11;
    @(negedge clk); #1;
    req_valid = 1'b1; req_clear = 1'b0; req_chan = 2'd0; req_code = 12'h111;
    @(negedge clk); #1;
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    req_valid = 1'b1; req_chan = 2'd3; req_code = 12'hEEE;
    @(negedge clk); #1;
    req_valid = 1'b0;
    while (!done) begin @(negedge clk); #1; end
    exp_dac[0] = 12'h111;
    chk("R7 only one lane", lanes, 4'b0001);
    chk("R7 channel 3 unchanged", dac[3], exp_dac[3]);
    chk("R7 busy length unchanged", busy_cyc, WR_LEN);
    busy_cyc = 0;
    repeat (6) @(negedge clk);
    #1;
    chk("R7 no second sequence", busy_cyc, 0);
    chk("R9 channel 0 written", dac[0], 12'h111);

    // R1: reset during a write
    @(negedge clk); #1;
    req_valid = 1'b1; req_chan = 2'd1; req_code = 12'h321;
    @(negedge clk); #1;
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 mid-sequence reset", {busy, byte_hi, clr_n, ce_n}, {2'd0, 1'b1, 4'hF});
    @(negedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 no write after reset", dac[1], exp_dac[1]);

    // boundary codes after reset
    run_req(1'b0, 2'd3, 12'hFFF);
    run_req(1'b0, 2'd3, 12'h000);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule